// File: doc/BRIEF.md
# Two-Half Page Hamming Parity Engine

This block produces single-error-correcting Hamming check bytes for a 512-byte flash page as the page streams through a byte-wide data path. It splits the page into two independent 256-byte halves, A and B. For each half it keeps 16 line-parity bits and 6 column-parity bits. The host drives the engine with 8-bit mode commands. One command clears the parity state, one enables accumulation, one turns the 16-bit read port into a result window, and any other command parks the engine in plain data mode.

Correction itself stays with the host. It compares the stored check bytes with freshly computed ones and can fix one flipped bit per half, so up to two bits per page. The stored result survives ordinary data traffic until the next clear command.

Top module: `hpe_top`

## Requirements
- R1: After `rst`, the engine is in data mode with cleared parity and no dummy read pending. Entering result mode then returns 0xFFFF for every word.
- R2: Mode code 0xF4 clears both halves' parity and the byte counter, and arms a pending dummy read. Code 0xB4 enables accumulation, 0xD4 selects result readout and 0x94 selects data mode.
- R3: While a dummy read is pending, bytes offered in accumulate mode are ignored. The first `rd_req` after a clear, in any mode, retires the pending dummy read.
- R4: Line parity uses p, the XOR of all 8 bits of a byte at address a within its half (0..255). For each address bit k, LP(2k+1) accumulates p over bytes with a[k]=1, and LP(2k) accumulates p over bytes with a[k]=0.
- R5: Column parity uses c, the XOR of all accepted bytes of a half. For j = 0..2, CP(2j+1) is the XOR of the c bits whose index has bit j set, and CP(2j) is the XOR of those with bit j clear. The column byte holds CP5..CP0 in bits 7:2, with bits 1:0 fixed at 1.
- R6: All parity bits are reported inverted, so an erased half of 0xFF bytes yields three 0xFF bytes.
- R7: Accepted bytes 0..255 feed half A and bytes 256..511 feed half B. Bytes beyond the 512th are ignored until the next 0xF4.
- R8: The result words are as follows. Word 0 = {A LP15..8, A LP7..0}. Word 1 = {B LP7..0, A column byte}. Word 2 = {B column byte, B LP15..8}. Each word is written {high byte, low byte}.
- R9: In result mode, `rd_data` shows the word at an internal pointer, and each `rd_req` advances it. The fourth and later reads return 0xFFFF. Every 0xD4 restarts the pointer at word 0.
- R10: Outside accumulate mode, bytes do not touch the parity state. Re-entering 0xB4 continues at the same byte count, and data mode leaves a stored result intact.
- R11: Outside result mode, `rd_data` is 0xFFFF.
- R12: Any mode code other than the four listed acts as data mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode command strobe |
| mode_cmd | input | 8 | Mode command code |
| byte_vld | input | 1 | A page byte is on `byte_in` this cycle |
| byte_in | input | 8 | Page data byte |
| rd_req | input | 1 | 16-bit data-port read strobe |
| rd_data | output | 16 | Read data: result word or 0xFFFF |

## Verification
The bench replays several pages against a reference parity model: a pseudo-random page, an erased page, and an all-0xFF page with one flipped bit in each half. The random page exercises every line and column term together. The erased page separates inverted storage from plain storage. The single-flip page isolates the address and bit-position groupings, so a mis-wired parity term shows up. Further sequences cover a page fed across pauses in data mode and unknown modes, a partial page that stops inside half B, an overlong page, bytes sent while a dummy read is pending, and readout past the third word and after re-entering result mode.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
    localparam int BYTE_W     = 8;
    localparam int HALF_AW    = 8;
    localparam int NUM_HALVES = 2;
    localparam int LP_W       = 2 * HALF_AW;
    localparam int COL_AW     = $clog2(BYTE_W);
    localparam int CP_W       = 2 * COL_AW;
    localparam int PAGE_BYTES = NUM_HALVES * (1 << HALF_AW);
    localparam int CNT_W      = $clog2(PAGE_BYTES) + 1;
    localparam int HSEL_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int NUM_WORDS  = 3;
    localparam int PTR_W      = $clog2(NUM_WORDS + 1);

    localparam logic [7:0] CMD_DATA   = 8'h94;
    localparam logic [7:0] CMD_CLEAR  = 8'hF4;
    localparam logic [7:0] CMD_CALC   = 8'hB4;
    localparam logic [7:0] CMD_RESULT = 8'hD4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_CALC,
        ST_RESULT
    } eng_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] col_b;
        logic [BYTE_W-1:0] lp_hi;
        logic [BYTE_W-1:0] lp_lo;
    } half_code_t;

    function automatic logic [CP_W-1:0] cp_from_col(input logic [BYTE_W-1:0] col);
        logic [CP_W-1:0] cp;
        cp = '0;
        for (int j = 0; j < COL_AW; j++) begin
            for (int i = 0; i < BYTE_W; i++) begin
                if (((i >> j) & 1) != 0) cp[2*j+1] = cp[2*j+1] ^ col[i];
                else                     cp[2*j]   = cp[2*j]   ^ col[i];
            end
        end
        return cp;
    endfunction

    function automatic half_code_t pack_code(input logic [LP_W-1:0] lp,
                                             input logic [BYTE_W-1:0] col);
        half_code_t hc;
        logic [LP_W-1:0] inv_lp;
        inv_lp   = ~lp;
        hc.lp_lo = inv_lp[BYTE_W-1:0];
        hc.lp_hi = inv_lp[LP_W-1:BYTE_W];
        hc.col_b = {~cp_from_col(col), {(BYTE_W-CP_W){1'b1}}};
        return hc;
    endfunction
endpackage

// File: rtl/hpe_half_acc.sv
module hpe_half_acc
    import hpe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               en,
    input  logic [HALF_AW-1:0] addr,
    input  logic [BYTE_W-1:0]  din,
    output logic [LP_W-1:0]    lp_q,
    output logic [BYTE_W-1:0]  col_q
);
    logic            par;
    logic [LP_W-1:0] hit;

    assign par = ^din;

    for (genvar k = 0; k < HALF_AW; k++) begin : g_line
        assign hit[2*k+1] = par &  addr[k];
        assign hit[2*k]   = par & ~addr[k];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lp_q  <= '0;
            col_q <= '0;
        end else if (en) begin
            lp_q  <= lp_q ^ hit;
            col_q <= col_q ^ din;
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lp_q == '0) && (col_q == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> ($stable(lp_q) && $stable(col_q)));
endmodule

// File: rtl/hpe_mode_ctrl.sv
module hpe_mode_ctrl
    import hpe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_wr,
    input  logic [7:0]            mode_cmd,
    input  logic                  byte_vld,
    input  logic                  rd_req,
    output logic                  clr,
    output logic                  ptr_clr,
    output logic                  result_mode,
    output logic [NUM_HALVES-1:0] half_en,
    output logic [HALF_AW-1:0]    half_addr
);
    eng_mode_e          mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               dummy_q;
    logic               accept;
    logic [HSEL_W-1:0]  hsel;

    assign clr         = mode_wr && (mode_cmd == CMD_CLEAR);
    assign ptr_clr     = mode_wr && (mode_cmd == CMD_RESULT);
    assign result_mode = (mode_q == ST_RESULT);
    assign accept      = byte_vld && (mode_q == ST_CALC) && !dummy_q
                         && (cnt_q < CNT_W'(PAGE_BYTES));
    assign hsel        = cnt_q[HALF_AW +: HSEL_W];
    assign half_addr   = cnt_q[HALF_AW-1:0];

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_en
        assign half_en[h] = accept && (hsel == HSEL_W'(h));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ST_IDLE;
        end else if (mode_wr) begin
            case (mode_cmd)
                CMD_CLEAR:  mode_q <= ST_CLEAR;
                CMD_CALC:   mode_q <= ST_CALC;
                CMD_RESULT: mode_q <= ST_RESULT;
                default:    mode_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (accept) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)         dummy_q <= 1'b0;
        else if (clr)    dummy_q <= 1'b1;
        else if (rd_req) dummy_q <= 1'b0;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(PAGE_BYTES));

    assert_one_half_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(half_en));

    assert_dummy_arm_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> dummy_q);

    assert_dummy_block_R3: assert property (@(posedge clk) disable iff (rst)
        (dummy_q && !clr && !rd_req) |=> $stable(cnt_q));
endmodule

// File: rtl/hpe_readout.sv
module hpe_readout
    import hpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_clr,
    input  logic              result_mode,
    input  logic              rd_req,
    input  half_code_t        code_a,
    input  half_code_t        code_b,
    output logic [WORD_W-1:0] rd_data
);
    logic [PTR_W-1:0]  ptr_q;
    logic [WORD_W-1:0] words [NUM_WORDS];

    always_comb begin
        words[0] = {code_a.lp_hi, code_a.lp_lo};
        words[1] = {code_b.lp_lo, code_a.col_b};
        words[2] = {code_b.col_b, code_b.lp_hi};
    end

    always_comb begin
        rd_data = '1;
        if (result_mode && (ptr_q < PTR_W'(NUM_WORDS))) rd_data = words[ptr_q];
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_clr) ptr_q <= '0;
        else if (result_mode && rd_req && (ptr_q < PTR_W'(NUM_WORDS)))
            ptr_q <= ptr_q + 1'b1;
    end

    assert_ptr_restart_R9: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (ptr_q == '0));

    assert_ptr_sat_R9: assert property (@(posedge clk) disable iff (rst)
        ((ptr_q == PTR_W'(NUM_WORDS)) && !ptr_clr) |=> (ptr_q == PTR_W'(NUM_WORDS)));
endmodule

// File: rtl/hpe_top.sv
module hpe_top
    import hpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [7:0]        mode_cmd,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data
);
    logic                  clr;
    logic                  ptr_clr;
    logic                  result_mode;
    logic [NUM_HALVES-1:0] half_en;
    logic [HALF_AW-1:0]    half_addr;
    logic [LP_W-1:0]       lp_arr  [NUM_HALVES];
    logic [BYTE_W-1:0]     col_arr [NUM_HALVES];
    half_code_t            codes   [NUM_HALVES];

    hpe_mode_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_cmd    (mode_cmd),
        .byte_vld    (byte_vld),
        .rd_req      (rd_req),
        .clr         (clr),
        .ptr_clr     (ptr_clr),
        .result_mode (result_mode),
        .half_en     (half_en),
        .half_addr   (half_addr)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        hpe_half_acc u_acc (
            .clk   (clk),
            .rst   (rst),
            .clr   (clr),
            .en    (half_en[h]),
            .addr  (half_addr),
            .din   (byte_in),
            .lp_q  (lp_arr[h]),
            .col_q (col_arr[h])
        );
        assign codes[h] = pack_code(lp_arr[h], col_arr[h]);
    end

    hpe_readout u_rd (
        .clk         (clk),
        .rst         (rst),
        .ptr_clr     (ptr_clr),
        .result_mode (result_mode),
        .rd_req      (rd_req),
        .code_a      (codes[0]),
        .code_b      (codes[1]),
        .rd_data     (rd_data)
    );
endmodule

// File: tb/tb_hpe_top.sv
`timescale 1ns/1ps
module tb_hpe_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_cmd = 8'h00;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        rd_req = 1'b0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    logic [7:0] pg [512];
    int  nacc = 0;
    bit  m_calc = 0, m_result = 0, m_dummy = 0;
    int  m_ptr = 0;

    always #2.5 clk = ~clk;

    hpe_top dut (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_cmd(mode_cmd),
        .byte_vld(byte_vld), .byte_in(byte_in), .rd_req(rd_req), .rd_data(rd_data)
    );

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] half_ref(input int h);
        logic [15:0] lp = '0;
        logic [7:0]  col = '0;
        logic [7:0]  b;
        logic        p;
        logic [5:0]  c;
        for (int i = 0; i < 256; i++) begin
            if (h*256 + i < nacc) begin
                b = pg[h*256 + i];
                p = ^b;
                for (int k = 0; k < 8; k++) begin
                    if (((i >> k) & 1) != 0) lp[2*k+1] = lp[2*k+1] ^ p;
                    else                     lp[2*k]   = lp[2*k] ^ p;
                end
                col = col ^ b;
            end
        end
        c[0] = col[0] ^ col[2] ^ col[4] ^ col[6];
        c[1] = col[1] ^ col[3] ^ col[5] ^ col[7];
        c[2] = col[0] ^ col[1] ^ col[4] ^ col[5];
        c[3] = col[2] ^ col[3] ^ col[6] ^ col[7];
        c[4] = col[0] ^ col[1] ^ col[2] ^ col[3];
        c[5] = col[4] ^ col[5] ^ col[6] ^ col[7];
        return {~c, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    function automatic logic [15:0] ref_word(input int w);
        logic [23:0] a, b;
        a = half_ref(0);
        b = half_ref(1);
        case (w)
            0:       return {a[15:8], a[7:0]};
            1:       return {b[7:0], a[23:16]};
            default: return {b[23:16], b[15:8]};
        endcase
    endfunction

    task automatic do_mode(input logic [7:0] c);
        @(negedge clk);
        mode_wr = 1'b1; mode_cmd = c;
        @(negedge clk);
        mode_wr = 1'b0;
        if (c == 8'hF4) begin nacc = 0; m_dummy = 1; end
        m_calc   = (c == 8'hB4);
        m_result = (c == 8'hD4);
        if (c == 8'hD4) m_ptr = 0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0;
        if (m_calc && !m_dummy && nacc < 512) begin
            pg[nacc] = b;
            nacc++;
        end
    endtask

    // Driver: pushes the expected word, then issues the read strobe.
    task automatic do_read(input string tag);
        logic [15:0] e;
        if (m_result) begin
            e = (m_ptr < 3) ? ref_word(m_ptr) : 16'hFFFF;
            if (m_ptr < 3) m_ptr++;
        end else begin
            e = 16'hFFFF;
        end
        m_dummy = 0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Monitor: compares each read against the scoreboard.
    always @(negedge clk) begin
        #1;
        if (rd_req) begin
            if (exp_q.size() == 0) begin
                check16("scoreboard-empty", rd_data, 16'hxxxx);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check16(t, rd_data, e);
            end
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 13) ^ (i >> 3) ^ (i << 5));
    endfunction

    task automatic read3(input string tag);
        for (int w = 0; w < 3; w++) do_read(tag);
    endtask

    task automatic fresh_calc();
        do_mode(8'hF4);
        do_read("R3/R11 dummy read");
        do_mode(8'hB4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check16("R1/R11 reset rd_data", rd_data, 16'hFFFF);

        // R1, R9: cleared result, then reads past the end
        do_mode(8'hD4);
        read3("R1 reset result");
        do_read("R9 fourth read");
        do_read("R9 fifth read");

        // R3: bytes while the dummy read is pending are dropped
        do_mode(8'hF4);
        do_mode(8'hB4);
        for (int i = 0; i < 4; i++) do_byte(8'hA5 + 8'(i));
        do_read("R3 dummy read in calc mode");
        // R4, R5, R7, R8: pseudo-random page plus overflow bytes
        for (int i = 0; i < 520; i++) do_byte(pat(i));
        do_mode(8'hD4);
        read3("R4/R5/R8 random page");
        do_read("R9 past end");

        // R9 restart, R10/R11 data mode preserves the result
        do_mode(8'hD4);
        read3("R9 restart");
        do_mode(8'h94);
        do_read("R11 data mode read");
        for (int i = 0; i < 10; i++) do_byte(8'h3C);
        do_mode(8'hD4);
        read3("R10 result kept");

        // R6: erased page
        fresh_calc();
        for (int i = 0; i < 512; i++) do_byte(8'hFF);
        do_mode(8'hD4);
        read3("R6 erased page");

        // R4, R5: one flipped bit per half
        fresh_calc();
        for (int i = 0; i < 512; i++) begin
            if (i == 8'h5A)            do_byte(8'hF7);
            else if (i == 256 + 8'hC3) do_byte(8'hBF);
            else                       do_byte(8'hFF);
        end
        do_mode(8'hD4);
        read3("R4/R5 single flip");

        // R10, R12, R7: paused page, unknown mode, partial half B
        fresh_calc();
        for (int i = 0; i < 100; i++) do_byte(pat(i + 7));
        do_mode(8'h94);
        for (int i = 0; i < 20; i++) do_byte(8'h11);
        do_mode(8'h37);
        do_read("R12 unknown mode read");
        for (int i = 0; i < 5; i++) do_byte(8'h22);
        do_mode(8'hB4);
        for (int i = 100; i < 300; i++) do_byte(pat(i + 7));
        do_mode(8'hD4);
        read3("R10/R12/R7 paused partial page");

        // R2: clear command wipes the stored result
        do_mode(8'hF4);
        do_read("R2 dummy after clear");
        do_mode(8'hD4);
        read3("R2 cleared result");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule